// File: doc/BRIEF.md
# CAN Controller Host Register File

This block is the processor-facing register set of an extended-format CAN controller. A byte-wide bus with one-cycle write and read strobes reaches the mode, command, status, interrupt-flag and interrupt-enable registers, plus a clock-divider byte. The block decodes the transmit, release-message and clear-overrun commands. It keeps a count of the receive messages that are still pending, and it drives a level interrupt to the host.

An address window at 16..28 changes meaning with the reset bit of the mode register. While the controller is held in reset, the first eight bytes of the window hold the acceptance code and mask bytes that the frame filter uses. While the controller is operating, writes to the window are forwarded one byte at a time to the transmit engine's buffer, and reads return bytes of the oldest receive message from the receive FIFO.

The block talks to the transmit engine and the FIFO only through single-cycle strobes. These are a transmit request out and a done pulse back, a message-stored pulse and an overrun pulse in, and a release pulse and a flush pulse out.

Top module: `can_hostregs`

## Requirements
- R1: After hardware reset the block reads mode (address 0) = 0x01, status (address 2) = 0x3C, interrupt flags (address 3) = 0x00 and clock divider (address 31) = 0x00, and `irq` is low.
- R2: A write to address 0 that does not set bit 0 from a cleared state stores only bits 4:0 of the data, and these read back with bits 7:5 as zero.
- R3: A mode write that changes bit 0 clears the pending-message count and drives `rx_flush` high for the one cycle after the write edge. Leaving reset (1 to 0) leaves the interrupt flags untouched.
- R4: A mode write that sets bit 0 while it is clear is a software reset. The mode becomes the written bits 3:1 with bit 4 cleared and bit 0 set. The status becomes (old & ~0x37) | 0x34, and the pending count is zero.
- R5: Writing bit 0 of the command register (address 1) pulses `tx_req` in the next cycle and clears status bits 2 (buffer free), 3 (transmit complete) and 5 (transmitting). A later `tx_done` pulse sets status bits 2 and 3 and interrupt-flag bit 1.
- R6: Command bit 2 releases the oldest message. When the pending count is non-zero, `rx_release` pulses in the next cycle and the count drops by one, and when it reaches zero interrupt bit 0 clears. When the count is zero there is no pulse and no change.
- R7: Command bit 3 clears status bit 1 (overrun) and interrupt bit 3.
- R8: An `rx_stored` pulse adds one pending message and sets interrupt bit 0. An `rx_overrun` pulse sets status bit 1 and interrupt bit 3. Both pulses clear status bit 4 (receiving). Status bit 0 reads 1 exactly when the pending count is non-zero.
- R9: `irq` is high whenever the enable register (address 4) ANDed with the interrupt flags is non-zero.
- R10: A read strobe on address 3 returns the flags and then clears them. Bit 0 is set again at once when messages remain pending.
- R11: Address 1 and addresses 5..15 read 0x00, and addresses 29 and 30 read 0xFF. Address 31 is a read/write byte. Writes to addresses 2 and 3 change nothing.
- R12: With mode bit 0 set, addresses 16..23 read and write the eight acceptance bytes, which appear on `acc_bytes` with address 16 in bits 7:0. Addresses 24..28 read 0x00, their writes are dropped, and no window write reaches `tx_wr`.
- R13: With mode bit 0 clear, a write to 16..28 pulses `tx_wr` in the next cycle with `tx_idx` = address-16 and the written data. A window read drives `rx_rd_idx` = address-16 and returns `rx_rd_data`. A write to address 16 sets status bit 5 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe (read side effects) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | Transmit request pulse |
| tx_done | input | 1 | Transmit engine finished |
| tx_wr | output | 1 | Transmit buffer byte write pulse |
| tx_idx | output | 4 | Transmit buffer byte index |
| tx_data | output | 8 | Transmit buffer byte |
| rx_stored | input | 1 | FIFO stored one message |
| rx_overrun | input | 1 | FIFO dropped a message |
| rx_release | output | 1 | Drop oldest message pulse |
| rx_flush | output | 1 | Empty the FIFO pulse |
| rx_rd_idx | output | 4 | Byte index into the oldest message |
| rx_rd_data | input | 8 | Byte returned by the FIFO |
| acc_bytes | output | 64 | Acceptance code/mask bytes |
| mode_bits | output | 5 | Current mode register |

## Verification
A pending count that has drifted shows up as a status bit 0 that disagrees with the number of stored and released messages. It also shows up as a bit-0 re-arm after a flag read that should not happen, and as a missing or extra `rx_release` pulse, all within the cycle that follows the command. Flag register errors appear on `irq` at the clock edge after the event, because the interrupt output is combinational from the flags. A wrong view of the reset bit shows up as window writes that leak to `tx_wr`, or as acceptance bytes that change while the controller is operating. The reference model is compared on every clock, so any of these is caught at the first cycle it reaches a port.

// File: rtl/can_hostregs_pkg.sv
`timescale 1ns/1ps
package can_hostregs_pkg;
  localparam int BYTE_W     = 8;
  localparam int MODE_W     = 5;
  localparam int WIN_BASE   = 16;
  localparam int WIN_LEN    = 13;
  localparam int ACC_N      = 8;
  localparam int WIN_IDX_W  = $clog2(WIN_LEN);
  localparam int ACC_IDX_W  = $clog2(ACC_N);
  localparam int ZERO_LO    = 5;
  localparam int ZERO_HI    = 15;

  localparam int A_MODE   = 0;
  localparam int A_CMD    = 1;
  localparam int A_STAT   = 2;
  localparam int A_INTR   = 3;
  localparam int A_IEN    = 4;
  localparam int A_CLKDIV = 31;

  // status bit positions
  localparam int ST_RXRDY  = 0;
  localparam int ST_OVR    = 1;
  localparam int ST_TXFREE = 2;
  localparam int ST_TXCMPL = 3;
  localparam int ST_RXBUSY = 4;
  localparam int ST_TXBUSY = 5;
  // interrupt flag positions
  localparam int IF_RX  = 0;
  localparam int IF_TX  = 1;
  localparam int IF_OVR = 3;
  // command bit positions
  localparam int CMD_TX   = 0;
  localparam int CMD_REL  = 2;
  localparam int CMD_CLRO = 3;
  localparam int MODE_RST = 0;

  localparam logic [BYTE_W-1:0] STAT_RESET = 8'h3C;
  localparam logic [MODE_W-1:0] MODE_RESET = 5'h01;

  typedef struct packed {
    logic mode;
    logic cmd;
    logic stat;
    logic intr;
    logic ien;
    logic clkdiv;
    logic zero;
    logic win;
    logic acc;
  } hit_t;

  function automatic logic [BYTE_W-1:0] swreset_status(input logic [BYTE_W-1:0] s);
    return (s & ~8'h37) | 8'h34;
  endfunction

  function automatic logic [MODE_W-1:0] swreset_mode(input logic [MODE_W-1:0] m);
    return (m & ~5'h11) | 5'h01;
  endfunction

  function automatic logic irq_level(input logic [BYTE_W-1:0] en, input logic [BYTE_W-1:0] fl);
    return |(en & fl);
  endfunction
endpackage

// File: rtl/canreg_decode.sv
`timescale 1ns/1ps
module canreg_decode
  import can_hostregs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0]    addr,
  output hit_t                 hit,
  output logic [WIN_IDX_W-1:0] win_idx
);
  logic [ADDR_W-1:0] off;

  always_comb begin
    off     = addr - ADDR_W'(WIN_BASE);
    win_idx = off[WIN_IDX_W-1:0];
    hit     = '0;
    if (addr == ADDR_W'(A_MODE))        hit.mode   = 1'b1;
    else if (addr == ADDR_W'(A_CMD))    hit.cmd    = 1'b1;
    else if (addr == ADDR_W'(A_STAT))   hit.stat   = 1'b1;
    else if (addr == ADDR_W'(A_INTR))   hit.intr   = 1'b1;
    else if (addr == ADDR_W'(A_IEN))    hit.ien    = 1'b1;
    else if (addr == ADDR_W'(A_CLKDIV)) hit.clkdiv = 1'b1;
    else if (addr >= ADDR_W'(ZERO_LO) && addr <= ADDR_W'(ZERO_HI)) hit.zero = 1'b1;
    else if (addr >= ADDR_W'(WIN_BASE) && addr < ADDR_W'(WIN_BASE + WIN_LEN)) begin
      hit.win = 1'b1;
      hit.acc = (off < ADDR_W'(ACC_N));
    end
  end
endmodule

// File: rtl/canreg_msgcnt.sv
`timescale 1ns/1ps
module canreg_msgcnt #(
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic store,
  input  logic rel_req,
  input  logic clear,
  output logic pend,
  output logic pend_nxt,
  output logic rel_fire,
  output logic drained
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    rel_fire = rel_req && (cnt_q != '0) && !clear;
    cnt_nxt  = cnt_q;
    if (clear) begin
      cnt_nxt = '0;
    end else begin
      if (rel_fire) cnt_nxt = cnt_nxt - 1'b1;
      if (store && cnt_nxt != CNT_MAX) cnt_nxt = cnt_nxt + 1'b1;
    end
    pend     = (cnt_q != '0);
    pend_nxt = (cnt_nxt != '0);
    drained  = rel_fire && !pend_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R6: a granted release with no concurrent store lowers the count by one
  p_release_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && cnt_q != '0 && !store && !clear) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R3: a flush leaves no pending message
  p_flush_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pend);
  // R8: a store never leaves the count at zero
  p_store_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !clear) |=> pend);
endmodule

// File: rtl/canreg_irqflags.sv
`timescale 1ns/1ps
module canreg_irqflags
  import can_hostregs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] en,
  input  logic              set_rx,
  input  logic              set_tx,
  input  logic              set_ovr,
  input  logic              clr_ovr,
  input  logic              rd_clr,
  input  logic              drained,
  input  logic              pend_nxt,
  output logic [BYTE_W-1:0] flags,
  output logic              irq
);
  logic [BYTE_W-1:0] fl_nxt;

  always_comb begin
    fl_nxt = flags;
    if (rd_clr)  fl_nxt = {{(BYTE_W-1){1'b0}}, pend_nxt};
    if (drained) fl_nxt[IF_RX]  = 1'b0;
    if (clr_ovr) fl_nxt[IF_OVR] = 1'b0;
    if (set_rx)  fl_nxt[IF_RX]  = 1'b1;
    if (set_tx)  fl_nxt[IF_TX]  = 1'b1;
    if (set_ovr) fl_nxt[IF_OVR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= fl_nxt;
  end

  assign irq = irq_level(en, flags);

  // R10: a flag read re-arms the receive bit while messages remain
  p_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && pend_nxt) |=> flags[IF_RX]);
  // R10: a flag read with no new event leaves only bit 0 possibly set
  p_readclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_tx && !set_ovr) |=> (flags[BYTE_W-1:1] == '0));
  // R9: nothing enabled means no interrupt
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

// File: rtl/can_hostregs.sv
`timescale 1ns/1ps
module can_hostregs
  import can_hostregs_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int MSG_CNT_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BYTE_W-1:0]       bus_wdata,
  output logic [BYTE_W-1:0]       bus_rdata,
  output logic                    irq,
  output logic                    tx_req,
  input  logic                    tx_done,
  output logic                    tx_wr,
  output logic [WIN_IDX_W-1:0]    tx_idx,
  output logic [BYTE_W-1:0]       tx_data,
  input  logic                    rx_stored,
  input  logic                    rx_overrun,
  output logic                    rx_release,
  output logic                    rx_flush,
  output logic [WIN_IDX_W-1:0]    rx_rd_idx,
  input  logic [BYTE_W-1:0]       rx_rd_data,
  output logic [ACC_N*BYTE_W-1:0] acc_bytes,
  output logic [MODE_W-1:0]       mode_bits
);
  hit_t                 hit;
  logic [WIN_IDX_W-1:0] win_idx;
  logic [ACC_IDX_W-1:0] acc_idx;

  logic [MODE_W-1:0] mode_q;
  logic [BYTE_W-1:0] stat_q, stat_nxt, status_rd;
  logic [BYTE_W-1:0] ien_q, clkdiv_q, flags;
  logic [BYTE_W-1:0] acc_q [ACC_N];

  // named internal events
  logic mode_wr, enter_rst, leave_rst, flush_ev;
  logic cmd_wr, tx_fire, rel_cmd, clro_cmd, intr_rd, win_wr, win16_wr;
  logic pend, pend_nxt, rel_fire, drained;
  logic in_rst;

  canreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit(hit), .win_idx(win_idx)
  );

  assign acc_idx   = win_idx[ACC_IDX_W-1:0];
  assign in_rst    = mode_q[MODE_RST];
  assign mode_wr   = bus_wr && hit.mode;
  assign enter_rst = mode_wr && !in_rst && bus_wdata[MODE_RST];
  assign leave_rst = mode_wr && in_rst && !bus_wdata[MODE_RST];
  assign flush_ev  = enter_rst || leave_rst;
  assign cmd_wr    = bus_wr && hit.cmd;
  assign tx_fire   = cmd_wr && bus_wdata[CMD_TX];
  assign rel_cmd   = cmd_wr && bus_wdata[CMD_REL];
  assign clro_cmd  = cmd_wr && bus_wdata[CMD_CLRO];
  assign intr_rd   = bus_rd && hit.intr;
  assign win_wr    = bus_wr && hit.win;
  assign win16_wr  = win_wr && (win_idx == '0);

  canreg_msgcnt #(.CNT_W(MSG_CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .store(rx_stored), .rel_req(rel_cmd),
    .clear(flush_ev), .pend(pend), .pend_nxt(pend_nxt),
    .rel_fire(rel_fire), .drained(drained)
  );

  canreg_irqflags u_irq (
    .clk(clk), .rst_n(rst_n), .en(ien_q),
    .set_rx(rx_stored), .set_tx(tx_done), .set_ovr(rx_overrun),
    .clr_ovr(clro_cmd), .rd_clr(intr_rd), .drained(drained),
    .pend_nxt(pend_nxt), .flags(flags), .irq(irq)
  );

  // status: held bits, bit 0 comes from the pending count
  always_comb begin
    stat_nxt = stat_q;
    if (tx_fire) begin
      stat_nxt[ST_TXFREE] = 1'b0;
      stat_nxt[ST_TXCMPL] = 1'b0;
      stat_nxt[ST_TXBUSY] = 1'b0;
    end
    if (tx_done) begin
      stat_nxt[ST_TXFREE] = 1'b1;
      stat_nxt[ST_TXCMPL] = 1'b1;
    end
    if (clro_cmd)                stat_nxt[ST_OVR]    = 1'b0;
    if (rx_overrun)              stat_nxt[ST_OVR]    = 1'b1;
    if (rx_stored || rx_overrun) stat_nxt[ST_RXBUSY] = 1'b0;
    if (win16_wr)                stat_nxt[ST_TXBUSY] = 1'b1;
    if (enter_rst)               stat_nxt = swreset_status(stat_nxt);
    stat_nxt[ST_RXRDY] = 1'b0;
  end

  assign status_rd = stat_q | {{(BYTE_W-1){1'b0}}, pend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_RESET;
      stat_q     <= STAT_RESET;
      ien_q      <= '0;
      clkdiv_q   <= '0;
      tx_req     <= 1'b0;
      rx_release <= 1'b0;
      rx_flush   <= 1'b0;
      tx_wr      <= 1'b0;
      tx_idx     <= '0;
      tx_data    <= '0;
    end else begin
      stat_q     <= stat_nxt;
      tx_req     <= tx_fire;
      rx_release <= rel_fire;
      rx_flush   <= flush_ev;
      tx_wr      <= win_wr && !in_rst;
      if (win_wr && !in_rst) begin
        tx_idx  <= win_idx;
        tx_data <= bus_wdata;
      end
      if (mode_wr) mode_q <= enter_rst ? swreset_mode(bus_wdata[MODE_W-1:0])
                                       : bus_wdata[MODE_W-1:0];
      if (bus_wr && hit.ien)    ien_q    <= bus_wdata;
      if (bus_wr && hit.clkdiv) clkdiv_q <= bus_wdata;
    end
  end

  // acceptance bytes, writable only while held in reset
  for (genvar g = 0; g < ACC_N; g++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q[g] <= '0;
      else if (win_wr && in_rst && hit.acc && acc_idx == ACC_IDX_W'(g)) acc_q[g] <= bus_wdata;
    end
    assign acc_bytes[g*BYTE_W +: BYTE_W] = acc_q[g];
  end

  always_comb begin
    bus_rdata = 8'hFF;
    if (hit.mode)        bus_rdata = {{(BYTE_W-MODE_W){1'b0}}, mode_q};
    else if (hit.cmd)    bus_rdata = 8'h00;
    else if (hit.stat)   bus_rdata = status_rd;
    else if (hit.intr)   bus_rdata = flags;
    else if (hit.ien)    bus_rdata = ien_q;
    else if (hit.clkdiv) bus_rdata = clkdiv_q;
    else if (hit.zero)   bus_rdata = 8'h00;
    else if (hit.win)    bus_rdata = in_rst ? (hit.acc ? acc_q[acc_idx] : 8'h00) : rx_rd_data;
  end

  assign rx_rd_idx = win_idx;
  assign mode_bits = mode_q;

  // R5: a transmit command leaves the transmit status bits cleared
  p_tx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !tx_done) |=> (!status_rd[ST_TXFREE] && !status_rd[ST_TXCMPL]));
  // R5: completion restores status and raises the transmit flag
  p_tx_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (status_rd[ST_TXFREE] && status_rd[ST_TXCMPL] && flags[IF_TX]));
  // R12: window writes in reset never reach the transmit buffer
  p_reset_window_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit.win && mode_q[MODE_RST]) |=> !tx_wr);
  // R4: entering reset gives a clean mode and an empty message count
  p_sw_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_rst |=> (mode_q[MODE_RST] && !mode_q[4] && !status_rd[ST_RXRDY]));
  // R11: at most one register selected
  p_one_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit.mode, hit.cmd, hit.stat, hit.intr, hit.ien, hit.clkdiv, hit.zero, hit.win}));
endmodule

// File: tb/can_hostregs_tb.sv
`timescale 1ns/1ps
module can_hostregs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       b_wr = 1'b0, b_rd = 1'b0;
  logic [4:0] b_addr = '0;
  logic [7:0] b_wd = '0;
  logic       tx_done = 1'b0, rx_st = 1'b0, rx_ovr = 1'b0;
  logic [7:0] rdata, tx_data, rx_rd_data;
  logic       irq, tx_req, tx_wr, rx_release, rx_flush;
  logic [3:0] tx_idx, rx_rd_idx;
  logic [63:0] acc_bytes;
  logic [4:0] mode_bits;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign rx_rd_data = 8'hA0 ^ {4'h0, rx_rd_idx};

  can_hostregs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
    .bus_wdata(b_wd), .bus_rdata(rdata), .irq(irq), .tx_req(tx_req),
    .tx_done(tx_done), .tx_wr(tx_wr), .tx_idx(tx_idx), .tx_data(tx_data),
    .rx_stored(rx_st), .rx_overrun(rx_ovr), .rx_release(rx_release),
    .rx_flush(rx_flush), .rx_rd_idx(rx_rd_idx), .rx_rd_data(rx_rd_data),
    .acc_bytes(acc_bytes), .mode_bits(mode_bits)
  );

  // behavioural reference model
  logic [7:0] m_mode, m_stat, m_int, m_en, m_clk;
  logic [7:0] m_acc [8];
  int         m_cnt;
  logic       e_txreq, e_rel, e_flush, e_txwr;
  logic [3:0] e_idx;
  logic [7:0] e_data;
  logic [7:0] ns, ni;
  int         nc;

  function automatic logic [7:0] exp_rd(input logic [4:0] a);
    if (a == 0) return m_mode;
    if (a == 2) return (m_stat & 8'hFE) | {7'b0, m_cnt != 0};
    if (a == 3) return m_int;
    if (a == 4) return m_en;
    if (a == 31) return m_clk;
    if (a <= 15) return 8'h00;
    if (a <= 28) begin
      if (m_mode[0]) return (a < 24) ? m_acc[a - 16] : 8'h00;
      return 8'hA0 ^ 8'(a - 16);
    end
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 8'h01; m_stat = 8'h3C; m_int = 0; m_en = 0; m_clk = 0; m_cnt = 0;
      for (int i = 0; i < 8; i++) m_acc[i] = 0;
      e_txreq = 0; e_rel = 0; e_flush = 0; e_txwr = 0; e_idx = 0; e_data = 0;
    end else begin
      e_txreq = 0; e_rel = 0; e_flush = 0; e_txwr = 0;
      ns = m_stat; ni = m_int; nc = m_cnt;
      if (rx_st)  begin nc = nc + 1; ni[0] = 1; ns[4] = 0; end
      if (rx_ovr) begin ns[1] = 1; ni[3] = 1; ns[4] = 0; end
      if (tx_done) begin ns = ns | 8'h0C; ni[1] = 1; end
      if (b_wr) begin
        if (b_addr == 0) begin
          if (b_wd[0] != m_mode[0]) begin
            e_flush = 1; nc = 0;
            if (b_wd[0]) ns = (ns & 8'hC8) | 8'h34;
          end
          m_mode = (b_wd[0] && !m_mode[0]) ? ((b_wd & 8'h0E) | 8'h01) : (b_wd & 8'h1F);
        end else if (b_addr == 1) begin
          if (b_wd[0]) begin e_txreq = 1; ns = ns & 8'hD3; end
          if (b_wd[2] && m_cnt > 0) begin e_rel = 1; nc = nc - 1; if (nc == 0) ni[0] = 0; end
          if (b_wd[3]) begin ns[1] = 0; ni[3] = 0; end
        end else if (b_addr == 4) m_en = b_wd;
        else if (b_addr == 31) m_clk = b_wd;
        else if (b_addr >= 16 && b_addr <= 28) begin
          if (b_addr == 16) ns[5] = 1;
          if (m_mode[0]) begin
            if (b_addr < 24) m_acc[b_addr - 16] = b_wd;
          end else begin
            e_txwr = 1; e_idx = 4'(b_addr - 16); e_data = b_wd;
          end
        end
      end
      if (b_rd && b_addr == 3) ni = {7'b0, nc != 0};
      m_stat = ns; m_int = ni; m_cnt = nc;
    end
  end

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison of every output against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R9",  "irq",        irq, |(m_en & m_int));
      check("R5",  "tx_req",     tx_req, e_txreq);
      check("R6",  "rx_release", rx_release, e_rel);
      check("R3",  "rx_flush",   rx_flush, e_flush);
      check("R13", "tx_wr",      tx_wr, e_txwr);
      if (e_txwr) check("R13", "tx_idx/data", {tx_idx, tx_data}, {e_idx, e_data});
      check("R12", "acc_bytes", acc_bytes,
            {m_acc[7], m_acc[6], m_acc[5], m_acc[4], m_acc[3], m_acc[2], m_acc[1], m_acc[0]});
      check("R2",  "mode_bits",  mode_bits, m_mode[4:0]);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); b_wr = 1; b_addr = a; b_wd = d;
    @(negedge clk); b_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    @(negedge clk); b_rd = 1; b_addr = a; #1;
    check(tag, $sformatf("read %0d", a), rdata, exp_rd(a));
    @(negedge clk); b_rd = 0;
  endtask

  task automatic rd_lit(input logic [4:0] a, input logic [7:0] v, input string tag);
    @(negedge clk); b_addr = a; #1;
    check(tag, $sformatf("peek %0d", a), rdata, v);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) tx_done = 1; else if (which == 1) rx_st = 1; else rx_ovr = 1;
    @(negedge clk); tx_done = 0; rx_st = 0; rx_ovr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd_lit(0, 8'h01, "R1"); rd_lit(2, 8'h3C, "R1");
    rd_lit(3, 8'h00, "R1"); rd_lit(31, 8'h00, "R1");
    check("R1", "irq after reset", irq, 1'b0);
    // R12 acceptance window while in reset
    for (int i = 0; i < 8; i++) wr(5'(16 + i), 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 8; i++) rd(5'(16 + i), "R12");
    wr(24, 8'h77); rd(24, "R12"); rd_lit(28, 8'h00, "R12");
    // R2/R3 leave reset, upper bits dropped
    wr(0, 8'hE8); rd_lit(0, 8'h08, "R2");
    // R11 map
    wr(31, 8'hA5); rd_lit(31, 8'hA5, "R11");
    rd_lit(1, 8'h00, "R11"); rd_lit(5, 8'h00, "R11"); rd_lit(15, 8'h00, "R11");
    rd_lit(29, 8'hFF, "R11"); rd_lit(30, 8'hFF, "R11");
    wr(2, 8'hFF); wr(3, 8'hFF); rd(2, "R11"); rd_lit(3, 8'h00, "R11");
    // R5 transmit and R9/R10 interrupt
    wr(4, 8'h0B);
    wr(1, 8'h01); rd_lit(2, 8'h10, "R5");
    pulse(0); rd_lit(2, 8'h1C, "R5");
    check("R9", "irq after tx done", irq, 1'b1);
    rd(3, "R10"); rd_lit(3, 8'h00, "R10");
    // R13 operating window
    wr(17, 8'h5A); wr(16, 8'h33); rd_lit(2, 8'h3C, "R13");
    rd(20, "R13"); rd_lit(26, 8'hAA, "R13");
    // R8 stores, R10 re-arm, R6 releases
    pulse(1); pulse(1); rd_lit(2, 8'h2D, "R8");
    rd(3, "R10"); rd_lit(3, 8'h01, "R10");
    wr(1, 8'h04); rd_lit(3, 8'h01, "R6"); rd(2, "R6");
    wr(1, 8'h04); rd_lit(3, 8'h00, "R6"); rd_lit(2, 8'h2C, "R6");
    wr(1, 8'h04); rd(2, "R6");
    // R8 overrun, R7 clear
    pulse(2); rd_lit(2, 8'h2E, "R8"); rd_lit(3, 8'h08, "R8");
    check("R9", "irq on overrun", irq, 1'b1);
    wr(1, 8'h08); rd_lit(2, 8'h2C, "R7"); rd_lit(3, 8'h00, "R7");
    // R4 software reset with a pending message
    pulse(1); wr(0, 8'h13); rd_lit(0, 8'h03, "R4"); rd_lit(2, 8'h3C, "R4");
    check("R9", "irq with stale rx flag", irq, 1'b1);
    wr(4, 8'h00); check("R9", "irq masked", irq, 1'b0);
    // R3 leaving reset drops pending messages
    pulse(1); wr(0, 8'h00); rd_lit(2, 8'h2C, "R3"); rd(3, "R3");
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule